// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block controls how a CAN controller comes back from the bus-off state. When the error logic reports bus-off, the block raises the initialization flag, which halts all bus traffic. It then waits until software lowers that flag. After that it watches the sampled receive line, one bit per bit-time strobe. It counts idle periods, where each period is eleven recessive bits in a row. When the 129th period completes, it sends a one-clock pulse that zeroes the transmit and receive error counters and returns the controller to normal operation.

Each idle period counted during recovery also posts a Bit0 code to the last-error-code field of the status register. Software can use these updates to follow progress. It can also use them to tell a bus held dominant apart from a bus that is merely busy. Toggling the initialization flag never shortens recovery. Setting it freezes the sequence and keeps the number of idle periods already counted. Clearing it resumes counting from that number.

The controller is in one of four states:
- `ST_NORMAL`: normal operation, where software writes the init flag freely.
- `ST_BUSOFF`: bus-off with the init flag held high, waiting for software to clear it.
- `ST_RECOVER`: counting idle periods.
- `ST_FINISH`: a one-clock release state.

The transitions are:
- NORMAL→BUSOFF on a bus-off event.
- BUSOFF→RECOVER when software clears init.
- RECOVER→BUSOFF when software sets init.
- RECOVER→FINISH on the final idle period.
- FINISH→NORMAL unconditionally.

Top module: `canbo_recovery_seq`

## Requirements
- R1: After reset `init_flag` is 1, `bus_halt` is 1, and `busoff_flag`, `recovering`, `lec_wr` and `ec_clear` are 0.
- R2: In normal operation a `busoff_evt` pulse makes `busoff_flag`, `init_flag` and `bus_halt` 1 on the next clock, with `recovering` still 0.
- R3: While bus-off with the init flag set, strobed recessive bits produce no `lec_wr` and no progress.
- R4: A software clear of init while waiting in bus-off drops `init_flag` and raises `recovering` on the next clock, and counting starts from that clock.
- R5: During recovery, an idle period is 11 consecutive strobed recessive bits (`rx_bit`=1). In the clock after the strobe that carries the 11th bit, `lec_wr` pulses for one clock with `lec_code` = 3'd5 (Bit0). At all other times `lec_code` is 3'd0.
- R6: A strobed dominant bit (`rx_bit`=0) restarts the current run of recessive bits and keeps the number of idle periods already counted.
- R7: In the clock after the `lec_wr` of the 129th idle period, `ec_clear` is 1 for exactly one clock and `busoff_flag` is 0. On the following clock `recovering` and `bus_halt` are 0.
- R8: Setting init during recovery lowers `recovering`, raises `init_flag`, and discards the partial run of recessive bits. Clearing init resumes counting from the idle periods already counted, so the total stays 129.
- R9: Outside bus-off, `sw_init_set` and `sw_init_clr` write `init_flag` directly, and set wins when both are high. Strobed bits produce no `lec_wr`.
- R10: `rx_bit` is ignored in clocks where `bit_strobe` is 0.
- R11: A `busoff_evt` that arrives during recovery is ignored and recovery continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_strobe | input | 1 | One-clock strobe marking a sampled bit |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| busoff_evt | input | 1 | Bus-off report from the error logic |
| sw_init_set | input | 1 | Software write setting the init flag |
| sw_init_clr | input | 1 | Software write clearing the init flag |
| init_flag | output | 1 | Initialization flag |
| bus_halt | output | 1 | Bus transmission and reception halted |
| busoff_flag | output | 1 | Bus-off pending, cleared at counter reset |
| recovering | output | 1 | Recovery counting in progress |
| lec_wr | output | 1 | Status-register write strobe for the last-error-code field |
| lec_code | output | 3 | Code written with `lec_wr` (5 = Bit0) |
| ec_clear | output | 1 | One-clock pulse clearing both error counters |

## Verification
The results arrive at these clocks:
- A software write or a bus-off event shows on the flags one clock after the edge that samples it.
- `lec_wr` shows one clock after the edge that samples the 11th recessive strobe.
- `ec_clear` shows one clock after that `lec_wr`.

The driver holds each input for one full clock starting at a falling edge. It samples all outputs at falling edges, which keeps every check half a clock away from the edge that changes it. Whenever the driver sends a bit that should finish an idle period, it queues the expected event, Bit0 and possibly release. The monitor pops one queued item per observed `lec_wr` or `ec_clear`, so any early, extra or missing event is reported.

// File: rtl/canbo_pkg.sv
package canbo_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL,
        ST_BUSOFF,
        ST_RECOVER,
        ST_FINISH
    } rcv_state_t;

    localparam int          LEC_W    = 3;
    localparam logic [2:0]  LEC_NONE = 3'd0;
    localparam logic [2:0]  LEC_BIT0 = 3'd5;

endpackage

// File: rtl/canbo_run_det.sv
// Counts consecutive strobed recessive bits; emits a registered one-clock
// pulse when a run of RUN_LEN completes, then starts the next run from zero.
module canbo_run_det #(
    parameter int RUN_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_strobe,
    input  logic rx_bit,
    output logic run_pulse
);
    localparam int CW = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt   <= '0;
            run_pulse <= 1'b0;
        end else begin
            run_pulse <= 1'b0;
            if (!enable) begin
                run_cnt <= '0;
            end else if (bit_strobe) begin
                if (!rx_bit) begin
                    run_cnt <= '0;
                end else if (run_cnt == LAST) begin
                    run_cnt   <= '0;
                    run_pulse <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/canbo_idle_tally.sv
// Counts completed idle periods; flags the one that reaches IDLE_COUNT.
module canbo_idle_tally #(
    parameter int IDLE_COUNT = 129
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic idle_last
);
    localparam int TW = (IDLE_COUNT > 2) ? $clog2(IDLE_COUNT) : 1;
    localparam logic [TW-1:0] LAST = TW'(IDLE_COUNT - 1);

    logic [TW-1:0] tally;

    assign idle_last = count_en && (tally == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally <= '0;
        end else if (clear || idle_last) begin
            tally <= '0;
        end else if (count_en) begin
            tally <= tally + 1'b1;
        end
    end
endmodule

// File: rtl/canbo_recovery_seq.sv
module canbo_recovery_seq
    import canbo_pkg::*;
#(
    parameter int RUN_LEN    = 11,
    parameter int IDLE_COUNT = 129
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_strobe,
    input  logic             rx_bit,
    input  logic             busoff_evt,
    input  logic             sw_init_set,
    input  logic             sw_init_clr,
    output logic             init_flag,
    output logic             bus_halt,
    output logic             busoff_flag,
    output logic             recovering,
    output logic             lec_wr,
    output logic [LEC_W-1:0] lec_code,
    output logic             ec_clear
);
    rcv_state_t state_q, state_d;
    logic       init_q, init_d;
    logic       run_pulse;
    logic       idle_last;
    logic       count_en;

    assign count_en = run_pulse && (state_q == ST_RECOVER);

    canbo_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (state_q == ST_RECOVER),
        .bit_strobe (bit_strobe),
        .rx_bit     (rx_bit),
        .run_pulse  (run_pulse)
    );

    canbo_idle_tally #(.IDLE_COUNT(IDLE_COUNT)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_NORMAL),
        .count_en  (count_en),
        .idle_last (idle_last)
    );

    // next-state and init-flag decision
    always_comb begin
        state_d = state_q;
        init_d  = init_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (busoff_evt) begin
                    state_d = ST_BUSOFF;
                    init_d  = 1'b1;
                end else if (sw_init_set) begin
                    init_d = 1'b1;
                end else if (sw_init_clr) begin
                    init_d = 1'b0;
                end
            end
            ST_BUSOFF: begin
                if (sw_init_clr && !sw_init_set) begin
                    init_d  = 1'b0;
                    state_d = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (sw_init_set) begin
                    init_d  = 1'b1;
                    state_d = ST_BUSOFF;
                end else if (idle_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_NORMAL;
                if (sw_init_set) begin
                    init_d = 1'b1;
                end else if (sw_init_clr) begin
                    init_d = 1'b0;
                end
            end
            default: begin
                state_d = ST_NORMAL;
                init_d  = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_NORMAL;
            init_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            init_q  <= init_d;
        end
    end

    // outputs
    always_comb begin
        init_flag   = init_q;
        recovering  = (state_q == ST_RECOVER);
        busoff_flag = (state_q == ST_BUSOFF) || (state_q == ST_RECOVER);
        ec_clear    = (state_q == ST_FINISH);
        bus_halt    = init_q || busoff_flag;
        lec_wr      = count_en;
        lec_code    = count_en ? LEC_BIT0 : LEC_NONE;
    end
endmodule

// File: rtl/canbo_recovery_chk.sv
module canbo_recovery_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_strobe,
    input logic       rx_bit,
    input logic       busoff_evt,
    input logic       sw_init_set,
    input logic       sw_init_clr,
    input logic       init_flag,
    input logic       bus_halt,
    input logic       busoff_flag,
    input logic       recovering,
    input logic       lec_wr,
    input logic [2:0] lec_code,
    input logic       ec_clear
);
    // R2
    busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_evt && !busoff_flag && !ec_clear |=> busoff_flag && init_flag && bus_halt && !recovering);

    // R4
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_flag && !recovering && sw_init_clr && !sw_init_set |=> recovering && !init_flag);

    // R5
    lec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_wr |-> $past(bit_strobe && rx_bit) && lec_code == 3'd5);

    // R5
    lec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lec_wr |=> !lec_wr);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_clear |-> !busoff_flag && $past(lec_wr));

    // R7
    release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_clear |=> !ec_clear && !recovering);

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_init_set && recovering |=> init_flag && !recovering && busoff_flag);

    // R11
    ignore_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_evt && recovering && !sw_init_set |=> busoff_flag);
endmodule

bind canbo_recovery_seq canbo_recovery_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_strobe  (bit_strobe),
    .rx_bit      (rx_bit),
    .busoff_evt  (busoff_evt),
    .sw_init_set (sw_init_set),
    .sw_init_clr (sw_init_clr),
    .init_flag   (init_flag),
    .bus_halt    (bus_halt),
    .busoff_flag (busoff_flag),
    .recovering  (recovering),
    .lec_wr      (lec_wr),
    .lec_code    (lec_code),
    .ec_clear    (ec_clear)
);

// File: tb/canbo_recovery_seq_test.sv
`timescale 1ns/1ps
module canbo_recovery_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       rx_bit = 1'b1;
    logic       busoff_evt = 1'b0;
    logic       sw_init_set = 1'b0;
    logic       sw_init_clr = 1'b0;
    logic       init_flag, bus_halt, busoff_flag, recovering, lec_wr, ec_clear;
    logic [2:0] lec_code;

    int total = 0;
    int bad = 0;
    int lec_seen = 0;
    int clr_seen = 0;
    int item;
    int base;
    bit done = 1'b0;
    int exp_q[$];

    // model state
    bit m_rec = 1'b0;
    int m_run = 0;
    int m_tally = 0;

    localparam int EV_LEC = 1;
    localparam int EV_CLR = 2;

    always #2.5 clk = ~clk;

    canbo_recovery_seq uut (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
        .busoff_evt(busoff_evt), .sw_init_set(sw_init_set), .sw_init_clr(sw_init_clr),
        .init_flag(init_flag), .bus_halt(bus_halt), .busoff_flag(busoff_flag),
        .recovering(recovering), .lec_wr(lec_wr), .lec_code(lec_code), .ec_clear(ec_clear)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: one strobed bit, expectations pushed before the result is due
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_strobe = 1'b1;
        rx_bit = b;
        if (m_rec) begin
            if (b) begin
                m_run++;
                if (m_run == 11) begin
                    m_run = 0;
                    m_tally++;
                    exp_q.push_back(EV_LEC);
                    if (m_tally == 129) begin
                        exp_q.push_back(EV_CLR);
                        m_rec = 1'b0;
                        m_tally = 0;
                    end
                end
            end else begin
                m_run = 0;
            end
        end
        @(negedge clk);
        bit_strobe = 1'b0;
    endtask

    task automatic send_run(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic sw_write(input logic s, input logic c);
        @(negedge clk);
        sw_init_set = s;
        sw_init_clr = c;
        if (m_rec && s) begin
            m_rec = 1'b0;
            m_run = 0;
        end else if (busoff_flag && !recovering && c && !s) begin
            m_rec = 1'b1;
            m_run = 0;
        end
        @(negedge clk);
        sw_init_set = 1'b0;
        sw_init_clr = 1'b0;
    endtask

    task automatic pulse_busoff();
        @(negedge clk);
        busoff_evt = 1'b1;
        @(negedge clk);
        busoff_evt = 1'b0;
    endtask

    // monitor: pops the scoreboard on every produced event
    always @(negedge clk) begin
        if (rst_n) begin
            if (lec_wr) begin
                lec_seen++;
                if (exp_q.size() == 0) begin
                    check("R5 unexpected lec_wr", 1, 0);
                end else begin
                    item = exp_q.pop_front();
                    check("R5 event kind lec", item, EV_LEC);
                    check("R5 lec_code Bit0", int'(lec_code), 5);
                end
            end
            if (ec_clear) begin
                clr_seen++;
                if (exp_q.size() == 0) begin
                    check("R7 unexpected ec_clear", 1, 0);
                end else begin
                    item = exp_q.pop_front();
                    check("R7 event kind clear", item, EV_CLR);
                end
            end
            if (!lec_wr) check("R5 lec_code idle", int'(lec_code), 0);
        end
    end

    task automatic finish_checks();
        // last send_bit returned at the negedge showing lec_wr
        @(negedge clk);
        check("R7 ec_clear pulse", int'(ec_clear), 1);
        check("R7 busoff_flag cleared", int'(busoff_flag), 0);
        @(negedge clk);
        check("R7 ec_clear single", int'(ec_clear), 0);
        check("R7 recovering low", int'(recovering), 0);
        check("R7 bus_halt low", int'(bus_halt), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 init_flag", int'(init_flag), 1);
        check("R1 bus_halt", int'(bus_halt), 1);
        check("R1 busoff_flag", int'(busoff_flag), 0);
        check("R1 recovering", int'(recovering), 0);
        check("R1 ec_clear", int'(ec_clear), 0);

        // R9 software control in normal state
        sw_write(1'b0, 1'b1);
        check("R9 init cleared", int'(init_flag), 0);
        check("R9 halt released", int'(bus_halt), 0);
        sw_write(1'b1, 1'b1);
        check("R9 set wins", int'(init_flag), 1);
        sw_write(1'b0, 1'b1);
        check("R9 init cleared again", int'(init_flag), 0);
        send_run(15);
        #1 check("R9 no events in normal", lec_seen, 0);

        // R2 entry
        pulse_busoff();
        check("R2 busoff_flag", int'(busoff_flag), 1);
        check("R2 init_flag", int'(init_flag), 1);
        check("R2 bus_halt", int'(bus_halt), 1);
        check("R2 recovering", int'(recovering), 0);

        // R3 frozen while init set
        send_run(25);
        #1 check("R3 no events while init", lec_seen, 0);
        check("R3 not recovering", int'(recovering), 0);

        // R4 resume
        sw_write(1'b0, 1'b1);
        check("R4 recovering", int'(recovering), 1);
        check("R4 init low", int'(init_flag), 0);
        check("R4 still halted", int'(bus_halt), 1);

        // R6 dominant restarts run
        base = lec_seen;
        send_run(10);
        send_bit(1'b0);
        send_run(10);
        #1 check("R6 no event after broken run", lec_seen - base, 0);
        send_bit(1'b1);
        #1 check("R6 event after full run", lec_seen - base, 1);

        // R10 rx_bit ignored without strobe
        base = lec_seen;
        send_run(5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rx_bit = 1'b0;
        end
        @(negedge clk);
        rx_bit = 1'b1;
        send_run(6);
        #1 check("R10 unstrobed dominant ignored", lec_seen - base, 1);

        // R11 bus-off report during recovery
        pulse_busoff();
        check("R11 still recovering", int'(recovering), 1);
        check("R11 busoff_flag kept", int'(busoff_flag), 1);

        // R8 freeze keeps tally, discards partial run
        send_run(48 * 11);
        send_run(6);
        sw_write(1'b1, 1'b0);
        check("R8 frozen recovering", int'(recovering), 0);
        check("R8 frozen init", int'(init_flag), 1);
        check("R8 frozen busoff", int'(busoff_flag), 1);
        base = lec_seen;
        send_run(30);
        #1 check("R8 no events while frozen", lec_seen - base, 0);
        sw_write(1'b0, 1'b1);
        check("R8 resumed", int'(recovering), 1);
        send_run(78 * 11);
        #1 check("R8 not shortened", int'(busoff_flag), 1);
        check("R8 no clear yet", clr_seen, 0);
        send_run(11);
        finish_checks();
        check("R7 init stays low", int'(init_flag), 0);

        // second round: tally restarts from zero
        pulse_busoff();
        check("R2 second entry", int'(busoff_flag), 1);
        sw_write(1'b0, 1'b1);
        base = lec_seen;
        send_run(129 * 11);
        finish_checks();
        check("R7 second round events", lec_seen - base, 129);

        repeat (4) @(negedge clk);
        check("R7 scoreboard drained", exp_q.size(), 0);
        check("R7 clear count", clr_seen, 2);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule